// File: doc/BRIEF.md
# Capture-Compare Timer with Match Shortcuts

This block is a general-purpose up-counter with four capture/compare channels, driven by a small word-addressed register file. In timer mode it advances on a divided version of its clock. In counter mode it advances only when software strobes the COUNT task. Tasks are single-cycle strobes that software issues by writing bits of one task register. Several tasks may be issued in one write, with a fixed priority when they collide.

Each channel holds a 32-bit CC register. A CAPTURE task copies the live count into it. Whenever an increment lands on the value held in CC, the channel raises a sticky match flag. A match can also stop or zero the counter through per-channel shortcut bits. An enable mask gates the match flags onto one interrupt line.

Top module: `tick_capture_timer`

Register map (word addresses): 0x00 task, 0x01 match flags, 0x02 shortcuts, 0x03 interrupt mask, 0x04 mask set, 0x05 mask clear, 0x06 mode, 0x07 width, 0x08 prescaler, 0x10+n CC[n].

## Requirements
- R1: After reset the counter is 0 and halted. Every CC register, match flag, shortcut bit and mask bit is 0. The mode is timer (0), the width code is 0 (8 bits), the prescaler is 0 and irq_o is low.
- R2: Task bit 0 (START) makes the counter run from the following cycle. Task bit 1 (STOP) and task bit 4 (SHUTDOWN) halt it from the following cycle. A halted counter keeps its value.
- R3: In timer mode a running counter advances once every 2^p clock cycles, where p is the prescaler register (address 0x08). A written prescaler value above 9 is stored as 9.
- R4: Task bit 3 (CLEAR) sets the counter to 0. If it is issued in the same write as COUNT, CLEAR wins.
- R5: Task bit 2 (COUNT) adds one to a running counter in counter mode (mode register bit 0 = 1). In timer mode COUNT has no effect, and in counter mode the clock divider has no effect.
- R6: Task bit 8+n (CAPTURE n) copies the counter value present before that write's edge into CC[n]. CC[n] reads back at 0x10+n.
- R7: When an increment produces a value equal to CC[n], masked to the counter width, match flag n (bit n at 0x01) is set. The flag stays set until software writes a 1 to that bit.
- R8: Shortcut bit n (address 0x02) makes a match on channel n halt the counter, which then holds the matched value.
- R9: Shortcut bit 8+n makes a match on channel n leave the counter at 0 instead of the matched value. Counting then continues from 0.
- R10: irq_o is high exactly when some match flag n and mask bit n are both set. Writing 1s at 0x04 sets mask bits, writing 1s at 0x05 clears them, and 0x03 reads the mask.
- R11: Width code 0/1/2/3 at 0x07 selects an 8/16/24/32-bit counter that wraps to 0 past its top value.
- R12: The task register reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe, one register write per cycle |
| addr_i | input | 5 | Word address for both read and write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Masked OR of the match flags |

## Verification
The bench times every capture against a cycle count worked out from the start edge. A design that counted on the same edge as START, or that ran its divider one step out, would capture the wrong value. It issues CLEAR together with COUNT, and CLEAR together with CAPTURE: a design with the wrong priority would leave 1 in the counter, or capture 0 instead of the old count. A match with the clear shortcut set must leave 0 and then continue to 1. A stop shortcut must freeze the counter on the matched value. At 8 bits, CC values of 0x100 must match at the wrap, and at 16 bits the same values must not match before 256 counts. A design that compared unmasked values, or did not wrap, would show different match flags.

// File: rtl/tct_pkg.sv
package tct_pkg;
    localparam int unsigned CNT_W = 32;

    typedef enum logic [1:0] {
        WID_8  = 2'd0,
        WID_16 = 2'd1,
        WID_24 = 2'd2,
        WID_32 = 2'd3
    } width_e;

    typedef enum logic {
        MODE_TIMER   = 1'b0,
        MODE_COUNTER = 1'b1
    } mode_e;

    // task register bit positions
    localparam int unsigned TSK_START = 0;
    localparam int unsigned TSK_STOP  = 1;
    localparam int unsigned TSK_COUNT = 2;
    localparam int unsigned TSK_CLEAR = 3;
    localparam int unsigned TSK_SHUT  = 4;
    localparam int unsigned TSK_CAP0  = 8;
    // clear-shortcut field offset in the shortcut register
    localparam int unsigned SHC_OFS   = 8;

    // word addresses
    localparam int unsigned A_TASK   = 0;
    localparam int unsigned A_EVT    = 1;
    localparam int unsigned A_SHORTS = 2;
    localparam int unsigned A_INTEN  = 3;
    localparam int unsigned A_INTSET = 4;
    localparam int unsigned A_INTCLR = 5;
    localparam int unsigned A_MODE   = 6;
    localparam int unsigned A_WIDTH  = 7;
    localparam int unsigned A_PRESC  = 8;
    localparam int unsigned A_CC0    = 16;

    function automatic logic [CNT_W-1:0] width_mask(width_e w);
        case (w)
            WID_8:   return 32'h0000_00FF;
            WID_16:  return 32'h0000_FFFF;
            WID_24:  return 32'h00FF_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction
endpackage

// File: rtl/tct_prescaler.sv
module tct_prescaler #(
    parameter int unsigned PRE_W   = 4,
    parameter int unsigned PRE_MAX = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             restart_i,
    input  logic [PRE_W-1:0] sel_i,
    output logic             tick_o
);
    localparam int unsigned DIV_W = (PRE_MAX > 0) ? PRE_MAX : 1;

    logic [DIV_W-1:0] div_d, div_q, limit;
    logic [DIV_W:0]   span;

    always_comb begin
        span   = (DIV_W+1)'(1) << sel_i;
        limit  = DIV_W'(span - 1'b1);
        tick_o = en_i && (div_q == limit);
        if (!en_i || restart_i || tick_o) div_d = '0;
        else                              div_d = div_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    p_tick_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> en_i);
endmodule

// File: rtl/tct_channel.sv
module tct_channel #(
    parameter int unsigned CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt_i,
    input  logic [CW-1:0] cnt_nx_i,
    input  logic [CW-1:0] mask_i,
    input  logic          inc_i,
    input  logic          cc_we_i,
    input  logic [CW-1:0] wdata_i,
    input  logic          cap_i,
    input  logic          evt_clr_i,
    output logic [CW-1:0] cc_o,
    output logic          evt_o,
    output logic          hit_o
);
    typedef struct packed {
        logic [CW-1:0] cc;
        logic          evt;
    } ch_t;

    ch_t ch_d, ch_q;

    always_comb begin
        ch_d  = ch_q;
        hit_o = inc_i && (cnt_nx_i == (ch_q.cc & mask_i));
        if (cap_i)        ch_d.cc = cnt_i;
        else if (cc_we_i) ch_d.cc = wdata_i;
        if (hit_o)          ch_d.evt = 1'b1;
        else if (evt_clr_i) ch_d.evt = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ch_q <= '0;
        else        ch_q <= ch_d;
    end

    assign cc_o  = ch_q.cc;
    assign evt_o = ch_q.evt;

    p_evt_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_o && !evt_clr_i) |=> evt_o);
    p_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cap_i |=> (cc_o == $past(cnt_i)));
endmodule

// File: rtl/tick_capture_timer.sv
module tick_capture_timer
    import tct_pkg::*;
#(
    parameter int unsigned NUM_CH  = 4,
    parameter int unsigned ADDR_W  = 5,
    parameter int unsigned PRE_W   = 4,
    parameter int unsigned PRE_MAX = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [31:0]       wdata_i,
    output logic [31:0]       rdata_o,
    output logic              irq_o
);
    typedef struct packed {
        logic              run;
        logic [CNT_W-1:0]  cnt;
        mode_e             mode;
        width_e            width;
        logic [PRE_W-1:0]  presc;
        logic [NUM_CH-1:0] sh_stop;
        logic [NUM_CH-1:0] sh_clr;
        logic [NUM_CH-1:0] inten;
    } ctl_t;

    ctl_t s_d, s_q;

    logic              wr_task, do_start, do_stop, do_count, do_clear, do_shut;
    logic              tmr_en, tick, inc, hit_clr, hit_stop;
    logic [CNT_W-1:0]  mask, cnt_nx;
    logic [NUM_CH-1:0] hit, evt, cap, cc_we, evt_clr;
    logic [CNT_W-1:0]  cc_w [NUM_CH];

    assign wr_task  = wr_en_i && (addr_i == ADDR_W'(A_TASK));
    assign do_start = wr_task && wdata_i[TSK_START];
    assign do_stop  = wr_task && wdata_i[TSK_STOP];
    assign do_count = wr_task && wdata_i[TSK_COUNT];
    assign do_clear = wr_task && wdata_i[TSK_CLEAR];
    assign do_shut  = wr_task && wdata_i[TSK_SHUT];
    assign tmr_en   = s_q.run && (s_q.mode == MODE_TIMER);
    assign mask     = width_mask(s_q.width);
    assign cnt_nx   = (s_q.cnt + 1'b1) & mask;
    assign inc      = s_q.run && ((s_q.mode == MODE_COUNTER) ? do_count : tick);

    tct_prescaler #(.PRE_W(PRE_W), .PRE_MAX(PRE_MAX)) u_div (
        .clk(clk), .rst_n(rst_n), .en_i(tmr_en), .restart_i(do_clear),
        .sel_i(s_q.presc), .tick_o(tick)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        assign cap[n]     = wr_task && wdata_i[TSK_CAP0 + n];
        assign cc_we[n]   = wr_en_i && (addr_i == ADDR_W'(A_CC0 + n));
        assign evt_clr[n] = wr_en_i && (addr_i == ADDR_W'(A_EVT)) && wdata_i[n];
        tct_channel #(.CW(CNT_W)) u_ch (
            .clk(clk), .rst_n(rst_n), .cnt_i(s_q.cnt), .cnt_nx_i(cnt_nx),
            .mask_i(mask), .inc_i(inc), .cc_we_i(cc_we[n]), .wdata_i(wdata_i),
            .cap_i(cap[n]), .evt_clr_i(evt_clr[n]), .cc_o(cc_w[n]),
            .evt_o(evt[n]), .hit_o(hit[n])
        );
    end

    assign hit_clr  = |(hit & s_q.sh_clr);
    assign hit_stop = |(hit & s_q.sh_stop);

    always_comb begin
        s_d = s_q;
        // counter: task clear beats everything, clear shortcut beats the new value
        if (do_clear)   s_d.cnt = '0;
        else if (inc)   s_d.cnt = hit_clr ? '0 : cnt_nx;
        // run state: any halt source beats start
        if (do_stop || do_shut || hit_stop) s_d.run = 1'b0;
        else if (do_start)                  s_d.run = 1'b1;
        if (wr_en_i) begin
            case (addr_i)
                ADDR_W'(A_SHORTS): begin
                    s_d.sh_stop = wdata_i[NUM_CH-1:0];
                    s_d.sh_clr  = wdata_i[SHC_OFS +: NUM_CH];
                end
                ADDR_W'(A_INTSET): s_d.inten = s_q.inten | wdata_i[NUM_CH-1:0];
                ADDR_W'(A_INTCLR): s_d.inten = s_q.inten & ~wdata_i[NUM_CH-1:0];
                ADDR_W'(A_MODE):   s_d.mode  = mode_e'(wdata_i[0]);
                ADDR_W'(A_WIDTH):  s_d.width = width_e'(wdata_i[1:0]);
                ADDR_W'(A_PRESC):  s_d.presc = (wdata_i[PRE_W-1:0] > PRE_W'(PRE_MAX))
                                               ? PRE_W'(PRE_MAX) : wdata_i[PRE_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            ADDR_W'(A_EVT):    rdata_o = 32'(evt);
            ADDR_W'(A_SHORTS): begin
                rdata_o[NUM_CH-1:0]         = s_q.sh_stop;
                rdata_o[SHC_OFS +: NUM_CH]  = s_q.sh_clr;
            end
            ADDR_W'(A_INTEN):  rdata_o = 32'(s_q.inten);
            ADDR_W'(A_MODE):   rdata_o = {31'b0, s_q.mode};
            ADDR_W'(A_WIDTH):  rdata_o = 32'(s_q.width);
            ADDR_W'(A_PRESC):  rdata_o = 32'(s_q.presc);
            default: ;
        endcase
        for (int n = 0; n < NUM_CH; n++)
            if (addr_i == ADDR_W'(A_CC0 + n)) rdata_o = cc_w[n];
    end

    assign irq_o = |(evt & s_q.inten);

    p_clear_task_r4: assert property (@(posedge clk) disable iff (!rst_n)
        do_clear |=> (s_q.cnt == '0));
    p_halted_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.run && !do_clear) |=> $stable(s_q.cnt));
    p_ctr_needs_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode == MODE_COUNTER && !do_count && !do_clear) |=> $stable(s_q.cnt));
    p_presc_clamp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.presc <= PRE_W'(PRE_MAX));
    p_stop_short_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hit_stop |=> !s_q.run);
    p_irq_needs_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (s_q.inten != '0));
endmodule

// File: tb/tick_capture_timer_tb_top.sv
module tick_capture_timer_tb_top;
    import tct_pkg::*;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    item_t q[$];
    bit    req_v = 1'b0;
    bit    done = 1'b0;
    int    checks = 0;
    int    fails = 0;

    localparam logic [31:0] T_START = 32'h1, T_STOP = 32'h2, T_COUNT = 32'h4,
                            T_CLEAR = 32'h8, T_SHUT = 32'h10;

    always #10 clk = ~clk;

    tick_capture_timer dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
    );

    // monitor: compares the scoreboard head away from the clock edges
    initial forever begin
        @(negedge clk);
        #2;
        if (req_v && q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it  = q.pop_front();
            act = it.is_irq ? {31'b0, irq} : rdata;
            checks++;
            if (act !== it.exp) begin
                fails++;
                $display("FAIL %s actual=%0h expected=%0h", it.tag, act, it.exp);
            end
        end
    end

    task automatic wr(input int a, input logic [31:0] d);
        addr = 5'(a); wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic chk(input int a, input logic [31:0] e, input string tag);
        item_t it;
        it.is_irq = 1'b0; it.exp = e; it.tag = tag;
        q.push_back(it);
        addr = 5'(a); req_v = 1'b1;
        @(negedge clk);
        req_v = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        item_t it;
        it.is_irq = 1'b1; it.exp = {31'b0, e}; it.tag = tag;
        q.push_back(it);
        req_v = 1'b1;
        @(negedge clk);
        req_v = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) wr(A_TASK, T_COUNT);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(A_EVT, 0, "R1"); chk(A_SHORTS, 0, "R1"); chk(A_INTEN, 0, "R1");
        chk(A_MODE, 0, "R1"); chk(A_WIDTH, 0, "R1"); chk(A_PRESC, 0, "R1");
        chk(A_CC0, 0, "R1"); chk(A_CC0 + 3, 0, "R1"); chk_irq(1'b0, "R1");

        // R2 timer mode, divide by 1: first increment one cycle after START
        wr(A_TASK, T_START);
        idle(5);
        wr(A_TASK, 32'h100);             // capture 0
        chk(A_CC0, 5, "R2");
        wr(A_TASK, T_STOP);              // counts once more on its own edge
        idle(3);
        wr(A_TASK, 32'h200);             // capture 1
        chk(A_CC0 + 1, 8, "R2");
        wr(A_TASK, T_START);
        wr(A_TASK, T_SHUT);
        idle(4);
        wr(A_TASK, 32'h400);             // capture 2
        chk(A_CC0 + 2, 9, "R2");

        // R3 prescaler clamp and divide by 4
        wr(A_PRESC, 12);
        chk(A_PRESC, 9, "R3");
        wr(A_PRESC, 2);
        wr(A_TASK, T_CLEAR);
        wr(A_TASK, T_START);
        idle(8);
        wr(A_TASK, 32'h100);
        chk(A_CC0, 2, "R3");
        wr(A_TASK, T_STOP);

        // R5 COUNT ignored in timer mode
        wr(A_PRESC, 9);
        wr(A_TASK, T_CLEAR);
        wr(A_TASK, T_START);
        pulses(3);
        wr(A_TASK, 32'h100);
        chk(A_CC0, 0, "R5");
        wr(A_TASK, T_STOP);

        // R5 counter mode
        wr(A_MODE, 1);
        wr(A_TASK, T_CLEAR);
        wr(A_TASK, T_START);
        idle(5);
        pulses(3);
        wr(A_TASK, 32'h100);
        chk(A_CC0, 3, "R5");
        // R4 CLEAR beats COUNT
        wr(A_TASK, T_CLEAR | T_COUNT);
        wr(A_TASK, 32'h100);
        chk(A_CC0, 0, "R4");
        // R6 capture with clear in one write sees the old value
        pulses(2);
        wr(A_TASK, T_CLEAR | 32'h200);
        chk(A_CC0 + 1, 2, "R6");

        // R7 / R10 sticky flags and interrupt mask
        wr(A_CC0, 3);
        wr(A_CC0 + 1, 6);
        wr(A_INTSET, 1);
        pulses(3);
        chk(A_EVT, 1, "R7");
        chk_irq(1'b1, "R10");
        pulses(1);
        chk(A_EVT, 1, "R7");
        wr(A_EVT, 1);
        chk(A_EVT, 0, "R7");
        chk_irq(1'b0, "R10");
        pulses(2);
        chk(A_EVT, 2, "R7");
        chk_irq(1'b0, "R10");
        wr(A_INTSET, 2);
        chk_irq(1'b1, "R10");
        chk(A_INTEN, 3, "R10");
        wr(A_INTCLR, 2);
        chk_irq(1'b0, "R10");
        chk(A_INTEN, 1, "R10");
        wr(A_EVT, 32'hF);

        // R9 clear shortcut on channel 2
        wr(A_TASK, T_CLEAR);
        wr(A_CC0 + 2, 2);
        wr(A_SHORTS, 32'h1 << (SHC_OFS + 2));
        chk(A_SHORTS, 32'h400, "R9");
        pulses(2);
        wr(A_TASK, 32'h100);
        chk(A_CC0, 0, "R9");
        chk(A_EVT, 4, "R9");
        pulses(1);
        wr(A_TASK, 32'h100);
        chk(A_CC0, 1, "R9");
        wr(A_EVT, 32'hF);

        // R8 stop shortcut on channel 3
        wr(A_TASK, T_CLEAR);
        wr(A_SHORTS, 32'h8);
        wr(A_CC0 + 3, 2);
        pulses(3);
        wr(A_TASK, 32'h200);
        chk(A_CC0 + 1, 2, "R8");
        wr(A_SHORTS, 0);
        wr(A_TASK, T_START);
        pulses(1);
        wr(A_TASK, 32'h200);
        chk(A_CC0 + 1, 3, "R8");

        // R11 8-bit wrap, compare on low bits
        wr(A_CC0, 0);
        wr(A_CC0 + 1, 32'h100);
        wr(A_CC0 + 2, 32'h100);
        wr(A_CC0 + 3, 32'h100);
        wr(A_TASK, T_CLEAR);
        wr(A_EVT, 32'hF);
        pulses(256);
        wr(A_TASK, 32'h200);
        chk(A_CC0 + 1, 0, "R11");
        chk(A_EVT, 32'hF, "R11");
        // R11 16-bit: no wrap at 256
        wr(A_CC0 + 1, 32'h100);
        wr(A_WIDTH, 1);
        wr(A_TASK, T_CLEAR);
        wr(A_EVT, 32'hF);
        pulses(256);
        wr(A_TASK, 32'h200);
        chk(A_CC0 + 1, 256, "R11");
        chk(A_EVT, 32'hE, "R11");

        // R12 task register reads 0
        chk(A_TASK, 0, "R12");

        idle(2);
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 200000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule